// File: doc/BRIEF.md
# Power-Up Reset Delay Sequencer

This block decides when the chip leaves reset after a power-on, a brownout or any other reset cause, and when the system clock can be trusted. A power-on or brownout event arms a long delay: a fixed power-on interval, plus a power-up timer interval when that timer is enabled. Every other reset cause releases the system reset on the next clock edge. All timing runs on one always-running slow reference clock `clk`. The primary oscillator's periods come in as single-cycle `osc_tick` strobes that are already synchronized to `clk`.

The clock-readiness waits start at the same event as the reset delay and run alongside it. The oscillator start-up count, the PLL lock filter and the internal RC start-up times each run on their own counter. The clock-source code decides which of these waits must finish before the clock is declared valid. With two-speed start-up, the system first runs from the internal fast RC clock. It hands over to the primary source once that source's waits are done. A fail-safe clock monitor enable follows the reset release. Every new reset event restarts the whole sequence and samples the configuration again.

Top module: `pwrseq_reset_seq`

## Requirements
- R1: After a power-on or brownout strobe sampled at edge E0, `sys_rst` is high and falls after edge E0+POR_TICKS+PWRT_TICKS+1 when `pwrt_en` was 1 at E0, or after edge E0+POR_TICKS+1 when it was 0.
- R2: After any other reset strobe sampled at edge E0, `sys_rst` falls after edge E0+1, whatever the value of `pwrt_en`.
- R3: A strobe in any phase clears every counter and restarts the sequence from that edge. `clk_sel`, `two_speed_en` and `pwrt_en` are captured only at a strobe edge, and changing them between strobes has no effect on any output.
- R4: `clk_sel` encodings and the waits each one needs: 0 external clock (none), 1 fast RC (FRC wait), 2 low-power RC (LPRC wait), 3 external with PLL (lock), 4 fast RC with PLL (FRC and lock), 5 crystal or secondary oscillator (start-up count), 6 crystal with PLL (start-up count and lock), 7 reserved (treated as 1). `clk_in_use` never shows 7.
- R5: The start-up count finishes on the edge that samples the OST_PERIODS-th `osc_tick` pulse after the event. The clock waits run in parallel with the reset delay, so `clk_valid` may rise while `sys_rst` is still high.
- R6: The lock wait needs `pll_lock` sampled high on LOCK_TICKS consecutive edges. A low sample before that point restarts the count. Once met, the wait stays met until the next event.
- R7: Two-speed start-up: `clk_valid` rises when the FRC wait or all primary waits finish, whichever comes first. `clk_in_use` reads 1 (fast RC) until the primary waits finish, and the captured code after that.
- R8: `fscm_en` is low while `sys_rst` is high, rises one edge after `sys_rst` falls, and is cleared by every event.
- R9: While `rst_n` is low, `sys_rst`=1, `clk_valid`=0, `fscm_en`=0 and `clk_in_use`=1. The first edge after `rst_n` rises acts as a power-on event.
- R10: Once high, `clk_valid` stays high until the next event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow reference clock that times every delay |
| rst_n | input | 1 | Asynchronous cold-start reset, active low |
| por_evt | input | 1 | Power-on reset cause strobe |
| bor_evt | input | 1 | Brownout reset cause strobe |
| oth_evt | input | 1 | Strobe for any other reset cause |
| pwrt_en | input | 1 | Power-up timer enable |
| clk_sel | input | 3 | Clock-source select code |
| two_speed_en | input | 1 | Start on fast RC, then switch to the primary source |
| osc_tick | input | 1 | One pulse per primary oscillator period, synchronized to `clk` |
| pll_lock | input | 1 | Raw PLL lock indication |
| sys_rst | output | 1 | System reset, active high |
| clk_valid | output | 1 | System clock is usable |
| clk_in_use | output | 3 | Code of the clock source currently driving the system |
| fscm_en | output | 1 | Fail-safe clock monitor enable |

## Verification
The bench sweeps every reset cause against both power-up timer settings and counts the exact release edge. An off-by-one in the delay counter, or a short delay that wrongly includes the timer, moves that edge. Each of the eight clock codes is run with and without two-speed start-up. Oscillator ticks are sent every cycle or every other cycle. The PLL lock is steady, has a glitch, or never arrives. A wrong wait table shows up as `clk_valid` rising early or late, or never rising. A lock filter that does not restart after a low sample validates too early. The configuration inputs are scrambled right after every event, so a design that reads them live instead of capturing them gives wrong timings. A restart in the middle of the sequence exposes counters that are not cleared.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

   localparam int unsigned SRC_W = 3;

   typedef enum logic [SRC_W-1:0] {
      SRC_EXT      = 3'd0,
      SRC_FRC      = 3'd1,
      SRC_LPRC     = 3'd2,
      SRC_EXT_PLL  = 3'd3,
      SRC_FRC_PLL  = 3'd4,
      SRC_XTAL     = 3'd5,
      SRC_XTAL_PLL = 3'd6,
      SRC_RSVD     = 3'd7
   } clk_src_e;

   // index order of the parallel wait counters
   localparam int unsigned W_FRC  = 0;
   localparam int unsigned W_LPRC = 1;
   localparam int unsigned W_OST  = 2;
   localparam int unsigned W_LOCK = 3;
   localparam int unsigned N_WAIT = 4;

   typedef struct packed {
      logic [SRC_W-1:0] sel;
      logic             two_speed;
      logic             pwrt_en;
   } seq_cfg_t;

   function automatic logic [N_WAIT-1:0] waits_for(input logic [SRC_W-1:0] code);
      logic [N_WAIT-1:0] w;
      w = '0;
      case (code)
         SRC_EXT:      w = '0;
         SRC_FRC:      w[W_FRC] = 1'b1;
         SRC_LPRC:     w[W_LPRC] = 1'b1;
         SRC_EXT_PLL:  w[W_LOCK] = 1'b1;
         SRC_FRC_PLL:  begin w[W_FRC] = 1'b1; w[W_LOCK] = 1'b1; end
         SRC_XTAL:     w[W_OST] = 1'b1;
         SRC_XTAL_PLL: begin w[W_OST] = 1'b1; w[W_LOCK] = 1'b1; end
         default:      w[W_FRC] = 1'b1;
      endcase
      return w;
   endfunction

   function automatic logic [SRC_W-1:0] effective_src(input logic [SRC_W-1:0] code);
      return (code == SRC_RSVD) ? SRC_FRC : code;
   endfunction

endpackage

// File: rtl/pwrseq_evt_ctrl.sv
module pwrseq_evt_ctrl
   import pwrseq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_evt,
   input  logic             bor_evt,
   input  logic             oth_evt,
   input  logic             pwrt_en,
   input  logic             two_speed_en,
   input  logic [SRC_W-1:0] clk_sel,
   output logic             restart,
   output logic             long_dly,
   output seq_cfg_t         cfg,
   output logic             armed
);

   logic pend_q;

   // a cold start behaves like a power-on event on the first edge
   assign restart  = por_evt | bor_evt | oth_evt | pend_q;
   assign long_dly = por_evt | bor_evt | pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q        <= 1'b1;
         armed         <= 1'b0;
         cfg.sel       <= SRC_FRC;
         cfg.two_speed <= 1'b0;
         cfg.pwrt_en   <= 1'b0;
      end else begin
         pend_q <= 1'b0;
         if (restart) begin
            armed         <= 1'b1;
            cfg.sel       <= clk_sel;
            cfg.two_speed <= two_speed_en;
            cfg.pwrt_en   <= pwrt_en;
         end
      end
   end

endmodule

// File: rtl/pwrseq_rst_timer.sv
module pwrseq_rst_timer #(
   parameter int unsigned POR_TICKS  = 64,
   parameter int unsigned PWRT_TICKS = 2048
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic long_dly,
   input  logic pwrt_en,
   output logic sys_rst,
   output logic fscm_en
);

   localparam int unsigned TOT = POR_TICKS + PWRT_TICKS;
   localparam int unsigned DW  = (TOT < 1) ? 1 : $clog2(TOT + 1);
   localparam logic [DW-1:0] TGT_FULL = DW'(TOT);
   localparam logic [DW-1:0] TGT_POR  = DW'(POR_TICKS);

   logic [DW-1:0] cnt_q;
   logic [DW-1:0] tgt_q;
   logic          rst_q;
   logic          fscm_q;
   logic [DW-1:0] tgt_new;

   always_comb begin
      if (!long_dly)    tgt_new = '0;
      else if (pwrt_en) tgt_new = TGT_FULL;
      else              tgt_new = TGT_POR;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         tgt_q  <= '0;
         rst_q  <= 1'b1;
         fscm_q <= 1'b0;
      end else if (restart) begin
         cnt_q  <= '0;
         tgt_q  <= tgt_new;
         rst_q  <= 1'b1;
         fscm_q <= 1'b0;
      end else begin
         if (rst_q) begin
            if (cnt_q == tgt_q) rst_q <= 1'b0;
            else                cnt_q <= cnt_q + DW'(1);
         end
         // monitor starts one edge after the release point
         fscm_q <= !rst_q;
      end
   end

   assign sys_rst = rst_q;
   assign fscm_en = fscm_q;

endmodule

// File: rtl/pwrseq_wait_cnt.sv
module pwrseq_wait_cnt #(
   parameter int unsigned LIMIT  = 1024,
   parameter bit          FILTER = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clear,
   input  logic inc,
   output logic done
);

   localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
   localparam logic [CW-1:0] LIM = CW'(LIMIT);

   logic [CW-1:0] cnt_q;

   assign done = (cnt_q == LIM);

   generate
      if (FILTER) begin : g_filter
         // consecutive-sample filter, sticky once met
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     cnt_q <= '0;
            else if (clear) cnt_q <= '0;
            else if (!done) cnt_q <= inc ? (cnt_q + CW'(1)) : '0;
         end
      end else begin : g_accum
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (clear)         cnt_q <= '0;
            else if (inc && !done)  cnt_q <= cnt_q + CW'(1);
         end
      end
   endgenerate

endmodule

// File: rtl/pwrseq_src_sel.sv
module pwrseq_src_sel
   import pwrseq_pkg::*;
(
   input  seq_cfg_t          cfg,
   input  logic              armed,
   input  logic [N_WAIT-1:0] wait_done,
   output logic              clk_valid,
   output logic [SRC_W-1:0]  clk_in_use
);

   logic [N_WAIT-1:0] need;
   logic              prim_ready;

   always_comb begin
      need       = waits_for(cfg.sel);
      prim_ready = &(~need | wait_done);
      clk_valid  = armed & (prim_ready | (cfg.two_speed & wait_done[W_FRC]));
      clk_in_use = (cfg.two_speed && !prim_ready) ? SRC_FRC : effective_src(cfg.sel);
   end

endmodule

// File: rtl/pwrseq_reset_seq.sv
module pwrseq_reset_seq
   import pwrseq_pkg::*;
#(
   parameter int unsigned POR_TICKS   = 64,
   parameter int unsigned PWRT_TICKS  = 2048,
   parameter int unsigned OST_PERIODS = 1024,
   parameter int unsigned FRC_TICKS   = 8,
   parameter int unsigned LPRC_TICKS  = 4,
   parameter int unsigned LOCK_TICKS  = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       por_evt,
   input  logic       bor_evt,
   input  logic       oth_evt,
   input  logic       pwrt_en,
   input  logic [2:0] clk_sel,
   input  logic       two_speed_en,
   input  logic       osc_tick,
   input  logic       pll_lock,
   output logic       sys_rst,
   output logic       clk_valid,
   output logic [2:0] clk_in_use,
   output logic       fscm_en
);

   generate
      if (OST_PERIODS < 1) begin : g_bad_ost
         $error("OST_PERIODS must be at least 1");
      end
      if (FRC_TICKS < 1) begin : g_bad_frc
         $error("FRC_TICKS must be at least 1");
      end
   endgenerate

   logic              restart;
   logic              long_dly;
   logic              armed;
   seq_cfg_t          cfg;
   logic [N_WAIT-1:0] wait_done;
   logic [N_WAIT-1:0] wait_inc;

   pwrseq_evt_ctrl u_evt (
      .clk          (clk),
      .rst_n        (rst_n),
      .por_evt      (por_evt),
      .bor_evt      (bor_evt),
      .oth_evt      (oth_evt),
      .pwrt_en      (pwrt_en),
      .two_speed_en (two_speed_en),
      .clk_sel      (clk_sel),
      .restart      (restart),
      .long_dly     (long_dly),
      .cfg          (cfg),
      .armed        (armed)
   );

   pwrseq_rst_timer #(
      .POR_TICKS  (POR_TICKS),
      .PWRT_TICKS (PWRT_TICKS)
   ) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .restart  (restart),
      .long_dly (long_dly),
      .pwrt_en  (pwrt_en),
      .sys_rst  (sys_rst),
      .fscm_en  (fscm_en)
   );

   always_comb begin
      wait_inc         = '1;
      wait_inc[W_OST]  = osc_tick;
      wait_inc[W_LOCK] = pll_lock;
   end

   genvar gi;
   generate
      for (gi = 0; gi < N_WAIT; gi++) begin : g_wait
         localparam int unsigned LIM =
            (gi == W_FRC)  ? FRC_TICKS  :
            (gi == W_LPRC) ? LPRC_TICKS :
            (gi == W_OST)  ? OST_PERIODS : LOCK_TICKS;
         pwrseq_wait_cnt #(
            .LIMIT  (LIM),
            .FILTER (gi == W_LOCK)
         ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clear (restart),
            .inc   (wait_inc[gi]),
            .done  (wait_done[gi])
         );
      end
   endgenerate

   pwrseq_src_sel u_sel (
      .cfg        (cfg),
      .armed      (armed),
      .wait_done  (wait_done),
      .clk_valid  (clk_valid),
      .clk_in_use (clk_in_use)
   );

endmodule

// File: rtl/pwrseq_reset_seq_chk.sv
module pwrseq_reset_seq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       por_evt,
   input logic       bor_evt,
   input logic       oth_evt,
   input logic       sys_rst,
   input logic       clk_valid,
   input logic [2:0] clk_in_use,
   input logic       fscm_en
);

   logic any_evt;
   assign any_evt = por_evt | bor_evt | oth_evt;

   p_evt_holds_rst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any_evt |=> sys_rst);

   p_release_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst) |-> !$past(any_evt));

   p_fscm_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fscm_en |-> !sys_rst);

   p_fscm_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fscm_en) |-> $past(!sys_rst));

   p_valid_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_valid && !any_evt) |=> clk_valid);

   p_inuse_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
      clk_in_use != 3'd7);

endmodule

bind pwrseq_reset_seq pwrseq_reset_seq_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .por_evt    (por_evt),
   .bor_evt    (bor_evt),
   .oth_evt    (oth_evt),
   .sys_rst    (sys_rst),
   .clk_valid  (clk_valid),
   .clk_in_use (clk_in_use),
   .fscm_en    (fscm_en)
);

// File: tb/sim_pwrseq_reset_seq.sv
module sim_pwrseq_reset_seq;

   localparam int CLK_P  = 10;
   localparam int POR_T  = 5;
   localparam int PWRT_T = 12;
   localparam int OST_T  = 8;
   localparam int FRC_T  = 3;
   localparam int LPRC_T = 6;
   localparam int LOCK_T = 4;
   localparam int MAXK   = 40;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       por_evt = 1'b0, bor_evt = 1'b0, oth_evt = 1'b0;
   logic       pwrt_en = 1'b0, two_speed_en = 1'b0;
   logic [2:0] clk_sel = 3'd1;
   logic       osc_tick = 1'b0, pll_lock = 1'b0;
   logic       sys_rst, clk_valid, fscm_en;
   logic [2:0] clk_in_use;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   pwrseq_reset_seq #(
      .POR_TICKS(POR_T), .PWRT_TICKS(PWRT_T), .OST_PERIODS(OST_T),
      .FRC_TICKS(FRC_T), .LPRC_TICKS(LPRC_T), .LOCK_TICKS(LOCK_T)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .por_evt(por_evt), .bor_evt(bor_evt),
      .oth_evt(oth_evt), .pwrt_en(pwrt_en), .clk_sel(clk_sel),
      .two_speed_en(two_speed_en), .osc_tick(osc_tick), .pll_lock(pll_lock),
      .sys_rst(sys_rst), .clk_valid(clk_valid), .clk_in_use(clk_in_use),
      .fscm_en(fscm_en)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // kind: 0 power-on, 1 brownout, 2 other, 3 cold start via rst_n
   task automatic fire(input int kind, input bit pw, input logic [2:0] sel, input bit ts);
      pwrt_en = pw; clk_sel = sel; two_speed_en = ts;
      osc_tick = 1'b0;
      por_evt = (kind == 0); bor_evt = (kind == 1); oth_evt = (kind == 2);
      if (kind == 3) rst_n = 1'b1;
      @(posedge clk); @(negedge clk);
      por_evt = 1'b0; bor_evt = 1'b0; oth_evt = 1'b0;
   endtask

   // tick_mode: 0 every cycle, 1 every other; lock_mode: 0 steady, 1 glitch, 2 never
   task automatic run_case(input int kind, input bit pw, input logic [2:0] sel, input bit ts,
                           input int tick_mode, input int lock_mode);
      int rel = -1, val = -1, fs = -1, drop = 0, fsbad = 0;
      int ostc = 0, ost_k = -1, lc = 0, lock_k = -1;
      int in_use_frc = -1, need_frc, need_lprc, need_ost, need_lock;
      int prim, exp_val, exp_rel, eff, exp_use_frc, exp_use_end;
      bit t, lk;
      string tag;
      fire(kind, pw, sel, ts);
      // R3: scramble configuration after capture
      pwrt_en = ~pw; clk_sel = ~sel; two_speed_en = ~ts;
      for (int k = 0; k <= MAXK; k++) begin
         if (!sys_rst && rel < 0) rel = k;
         if (clk_valid && val < 0) val = k;
         if (!clk_valid && val >= 0) drop = 1;
         if (fscm_en && fs < 0) fs = k;
         if (fscm_en && sys_rst) fsbad = 1;
         if (k == FRC_T) in_use_frc = int'(clk_in_use);
         t  = (tick_mode == 0) ? 1'b1 : (k % 2 == 0);
         lk = (lock_mode == 0) ? 1'b1 : (lock_mode == 2) ? 1'b0 : (k == 1 || k == 2 || k >= 4);
         if (t && ostc < OST_T) begin
            ostc++;
            if (ostc == OST_T) ost_k = k + 1;
         end
         if (lock_k < 0) begin
            lc = lk ? lc + 1 : 0;
            if (lc == LOCK_T) lock_k = k + 1;
         end
         osc_tick = t; pll_lock = lk;
         @(posedge clk); @(negedge clk);
      end
      osc_tick = 1'b0;
      // expected values from the wait table of R4
      need_frc  = (sel == 1 || sel == 4 || sel == 7);
      need_lprc = (sel == 2);
      need_ost  = (sel == 5 || sel == 6);
      need_lock = (sel == 3 || sel == 4 || sel == 6);
      prim = 0;
      if (need_frc)  prim = (FRC_T > prim) ? FRC_T : prim;
      if (need_lprc) prim = (LPRC_T > prim) ? LPRC_T : prim;
      if (need_ost)  prim = (ost_k < 0) ? -1 : ((ost_k > prim) ? ost_k : prim);
      if (need_lock && prim >= 0) prim = (lock_k < 0) ? -1 : ((lock_k > prim) ? lock_k : prim);
      if (ts) exp_val = (prim < 0 || prim > FRC_T) ? FRC_T : prim;
      else    exp_val = prim;
      exp_rel = (kind == 2) ? 1 : (pw ? POR_T + PWRT_T + 1 : POR_T + 1);
      eff = (sel == 7) ? 1 : int'(sel);
      exp_use_frc = (ts && (prim < 0 || prim > FRC_T)) ? 1 : eff;
      exp_use_end = (ts && prim < 0) ? 1 : eff;
      tag = $sformatf("kind=%0d pw=%0d sel=%0d ts=%0d", kind, pw, sel, ts);
      chk((kind == 2) ? "R2" : "R1", {"release edge ", tag}, rel, exp_rel);
      chk(ts ? "R7" : "R4", {"valid edge ", tag}, val, exp_val);
      chk("R7", {"source at FRC edge ", tag}, in_use_frc, exp_use_frc);
      chk("R4", {"source at end ", tag}, int'(clk_in_use), exp_use_end);
      chk("R8", {"monitor edge ", tag}, fs, exp_rel + 1);
      chk("R8", {"monitor while reset ", tag}, fsbad, 0);
      chk("R10", {"valid drop ", tag}, drop, 0);
      if (exp_val >= 0 && exp_val < exp_rel)
         chk("R5", {"valid before release ", tag}, int'(val < rel), 1);
   endtask

   initial begin
      #(CLK_P * 200000);
      checks++; errors++;
      $display("FAIL R1 watchdog expired: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      // R9: state while rst_n is held low
      repeat (3) @(negedge clk);
      chk("R9", "reset sys_rst", int'(sys_rst), 1);
      chk("R9", "reset clk_valid", int'(clk_valid), 0);
      chk("R9", "reset fscm_en", int'(fscm_en), 0);
      chk("R9", "reset clk_in_use", int'(clk_in_use), 1);
      // R9: cold start acts as a power-on event
      run_case(3, 1'b1, 3'd1, 1'b0, 0, 0);
      // R1 R2: every cause against both timer settings
      for (int kd = 0; kd < 3; kd++)
         for (int p = 0; p < 2; p++)
            run_case(kd, p[0], 3'd1, 1'b0, 0, 0);
      // R4 R7: every source code with and without two-speed
      for (int s = 0; s < 8; s++)
         for (int ts = 0; ts < 2; ts++)
            run_case(0, 1'b1, s[2:0], ts[0], 0, 0);
      // R5: sparse oscillator ticks
      run_case(0, 1'b0, 3'd5, 1'b0, 1, 0);
      run_case(2, 1'b0, 3'd6, 1'b1, 1, 0);
      // R6: lock glitch and missing lock
      run_case(2, 1'b0, 3'd3, 1'b0, 0, 1);
      run_case(0, 1'b1, 3'd6, 1'b0, 0, 1);
      run_case(0, 1'b0, 3'd4, 1'b0, 0, 2);
      run_case(0, 1'b0, 3'd3, 1'b1, 0, 2);
      // R3: restart in mid-sequence clears the counters
      fire(0, 1'b1, 3'd5, 1'b0);
      osc_tick = 1'b1;
      repeat (6) begin @(posedge clk); @(negedge clk); end
      run_case(2, 1'b1, 3'd5, 1'b0, 0, 0);
      fire(1, 1'b1, 3'd2, 1'b0);
      repeat (4) begin @(posedge clk); @(negedge clk); end
      run_case(0, 1'b0, 3'd2, 1'b0, 0, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule